// File: doc/BRIEF.md
# DS3 C-bit Parity Overhead Inserter

This block assembles a serial DS3 line in C-bit parity format. Each bit period is marked by an enable pulse. It walks a position counter through the 4760-bit multiframe and decides, for every enabled bit, whether the slot belongs to the payload or to the overhead. In a payload slot it raises a request strobe and passes the caller's payload bit straight to the serial output. In an overhead slot it emits the framing, multiframe-alignment, parity or C-bit value that belongs to that slot.

The multiframe is 7 subframes of 8 units. Each unit is one overhead bit followed by 84 payload bits. The X, FEAC, FEBE, data-link and user data-link values come from registered inputs. All of them are captured at the first bit of each multiframe, so one multiframe always carries one consistent set. The parity bits carry the even parity of the payload sent in the previous multiframe.

All three outputs are combinational from the current position and the inputs. The caller samples `ser_o` in the same cycle as the enable that produced it.

Top module: `ds3_oh_inserter`

## Requirements
- R1: A multiframe spans exactly 4760 enabled bit periods. `mf_start_o` is high only together with `bit_en_i`, at the first position of each multiframe, and never in the same cycle as `pay_req_o`.
- R2: Position p of the multiframe (0..4759) lies in unit p/85, and its offset within the unit is p mod 85. Offset 0 is the overhead bit and offsets 1..84 are payload. With `bit_en_i` high, `pay_req_o` is 1 exactly at the payload offsets (4704 per multiframe), and there `ser_o` equals `pay_data_i`.
- R3: Within every subframe, units 1 and 7 (counting units 0..7) carry a framing 1, and units 3 and 5 carry a framing 0.
- R4: Unit 0 of each subframe (subframes counted 0..6) carries a lead bit. It is X in subframes 0 and 1, P in subframes 2 and 3, and M in subframes 4, 5 and 6, with M values 0, 1 and 0 in that order.
- R5: Units 2, 4 and 6 carry C bits, numbered k = 0, 1, 2. In subframe 0, k=2 is `feac_i`. In subframe 1, k=0 is `udl_i[0]` and k=2 is `udl_i[1]`. Subframe 2 carries parity in all three C bits. Subframe 3 carries `febe_i[k]` and subframe 4 carries `dl_i[k]`. Subframe 5 carries `udl_i[2+k]` and subframe 6 carries `udl_i[5+k]`.
- R6: The application-identification C bit (subframe 0, k=0) and the two reserved C bits (subframe 0 k=1, subframe 1 k=1) are always 1.
- R7: Both P bits and all three parity C bits carry the XOR of every payload bit sent in the previous multiframe. They are 0 in the first multiframe after reset.
- R8: `x_i`, `feac_i`, `febe_i`, `dl_i` and `udl_i` are sampled at the first bit of a multiframe. A change made later takes effect only from the next multiframe.
- R9: While `bit_en_i` is low, the position does not advance, and both `pay_req_o` and `mf_start_o` are 0.
- R10: After reset the position is subframe 0, unit 0, overhead bit, and the parity is 0. The first enabled bit is therefore a multiframe start that carries X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | One line bit is produced in each cycle this is high |
| pay_data_i | input | 1 | Payload bit, used in cycles where `pay_req_o` is high |
| x_i | input | 1 | Value for both X bits |
| feac_i | input | 1 | Far-end alarm channel bit |
| febe_i | input | 3 | Far-end block error bits, index k |
| dl_i | input | 3 | Path data-link bits, index k |
| udl_i | input | 8 | User data-link bits |
| pay_req_o | output | 1 | High in enabled payload slots |
| ser_o | output | 1 | Serial line bit |
| mf_start_o | output | 1 | High in the enabled first bit of a multiframe |

## Verification
All three outputs are due in the same cycle as the enable they answer, with no register between input and output. The position, the field snapshot and the parity all update at the clock edge that ends that cycle. The bench therefore drives its inputs just after a falling edge, checks the outputs 1 ns later, before the next rising edge, and advances its own position model only for enabled cycles. Captured fields and parity are due one full multiframe later, so the bench holds its expectation of them from the first bit of the multiframe, or from the end of the previous one, and ignores changes made mid-frame.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;
  localparam int UNITS     = 8;
  localparam int SUBFRAMES = 7;
  localparam int CBITS     = 3;
  localparam int UDL_BITS  = 8;
  localparam int UW        = $clog2(UNITS);
  localparam int SW        = $clog2(SUBFRAMES);

  typedef struct packed {
    logic                x;
    logic                feac;
    logic [CBITS-1:0]    febe;
    logic [CBITS-1:0]    dl;
    logic [UDL_BITS-1:0] udl;
  } oh_fields_t;

  typedef enum logic [3:0] {
    OH_X, OH_P, OH_M, OH_F1, OH_F0, OH_AIC, OH_NA,
    OH_FEAC, OH_UDL, OH_CP, OH_FEBE, OH_DL
  } oh_kind_e;
endpackage

// File: rtl/ds3_pos_counter.sv
module ds3_pos_counter
  import ds3_oh_pkg::*;
#(
  parameter int PAY_BITS = 84
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          oh_slot_o,
  output logic [UW-1:0] unit_o,
  output logic [SW-1:0] sf_o,
  output logic          mf_first_o,
  output logic          mf_last_o
);
  localparam int BW = $clog2(PAY_BITS + 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(PAY_BITS);
  localparam logic [UW-1:0] LAST_UNIT = UW'(UNITS - 1);
  localparam logic [SW-1:0] LAST_SF   = SW'(SUBFRAMES - 1);

  logic [BW-1:0] bit_q;
  logic [UW-1:0] unit_q;
  logic [SW-1:0] sf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      unit_q <= '0;
      sf_q   <= '0;
    end else if (en_i) begin
      if (bit_q == LAST_BIT) begin
        bit_q <= '0;
        if (unit_q == LAST_UNIT) begin
          unit_q <= '0;
          sf_q   <= (sf_q == LAST_SF) ? '0 : sf_q + 1'b1;
        end else begin
          unit_q <= unit_q + 1'b1;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign oh_slot_o  = (bit_q == '0);
  assign unit_o     = unit_q;
  assign sf_o       = sf_q;
  assign mf_first_o = oh_slot_o && (unit_q == '0) && (sf_q == '0);
  assign mf_last_o  = (bit_q == LAST_BIT) && (unit_q == LAST_UNIT) && (sf_q == LAST_SF);
endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pay_en_i,
  input  logic data_i,
  input  logic mf_last_i,
  output logic par_o
);
  logic acc_q, par_q;

  // last multiframe position is always a payload slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
    end else if (pay_en_i) begin
      if (mf_last_i) begin
        par_q <= acc_q ^ data_i;
        acc_q <= 1'b0;
      end else begin
        acc_q <= acc_q ^ data_i;
      end
    end
  end

  assign par_o = par_q;
endmodule

// File: rtl/ds3_oh_snapshot.sv
module ds3_oh_snapshot
  import ds3_oh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  oh_fields_t fields_i,
  output oh_fields_t fields_o
);
  oh_fields_t snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (load_i) snap_q <= fields_i;
  end

  // first bit of a frame sees live inputs, the rest the captured copy
  assign fields_o = load_i ? fields_i : snap_q;
endmodule

// File: rtl/ds3_oh_mux.sv
module ds3_oh_mux
  import ds3_oh_pkg::*;
(
  input  logic [UW-1:0] unit_i,
  input  logic [SW-1:0] sf_i,
  input  logic          par_i,
  input  oh_fields_t    fields_i,
  output oh_kind_e      kind_o,
  output logic          bit_o
);
  logic [1:0] cidx;
  logic [2:0] udl_idx;

  assign cidx = unit_i[2:1] - 2'd1;

  always_comb begin
    kind_o  = OH_F1;
    udl_idx = '0;
    unique case (unit_i)
      3'd0: begin
        if (sf_i < 3'd2)      kind_o = OH_X;
        else if (sf_i < 3'd4) kind_o = OH_P;
        else                  kind_o = OH_M;
      end
      3'd1, 3'd7: kind_o = OH_F1;
      3'd3, 3'd5: kind_o = OH_F0;
      default: begin
        unique case (sf_i)
          3'd0: kind_o = (cidx == 2'd0) ? OH_AIC : (cidx == 2'd1) ? OH_NA : OH_FEAC;
          3'd1: begin
            kind_o  = (cidx == 2'd1) ? OH_NA : OH_UDL;
            udl_idx = (cidx == 2'd0) ? 3'd0 : 3'd1;
          end
          3'd2: kind_o = OH_CP;
          3'd3: kind_o = OH_FEBE;
          3'd4: kind_o = OH_DL;
          3'd5: begin
            kind_o  = OH_UDL;
            udl_idx = 3'd2 + {1'b0, cidx};
          end
          default: begin
            kind_o  = OH_UDL;
            udl_idx = 3'd5 + {1'b0, cidx};
          end
        endcase
      end
    endcase
  end

  always_comb begin
    unique case (kind_o)
      OH_X:    bit_o = fields_i.x;
      OH_P:    bit_o = par_i;
      OH_CP:   bit_o = par_i;
      OH_M:    bit_o = (sf_i == 3'd5);
      OH_F1:   bit_o = 1'b1;
      OH_F0:   bit_o = 1'b0;
      OH_AIC:  bit_o = 1'b1;
      OH_NA:   bit_o = 1'b1;
      OH_FEAC: bit_o = fields_i.feac;
      OH_UDL:  bit_o = fields_i.udl[udl_idx];
      OH_FEBE: bit_o = fields_i.febe[cidx];
      OH_DL:   bit_o = fields_i.dl[cidx];
      default: bit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ds3_oh_inserter.sv
module ds3_oh_inserter
  import ds3_oh_pkg::*;
#(
  parameter int PAY_BITS = 84
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_en_i,
  input  logic                pay_data_i,
  input  logic                x_i,
  input  logic                feac_i,
  input  logic [CBITS-1:0]    febe_i,
  input  logic [CBITS-1:0]    dl_i,
  input  logic [UDL_BITS-1:0] udl_i,
  output logic                pay_req_o,
  output logic                ser_o,
  output logic                mf_start_o
);
  logic          oh_slot, mf_first, mf_last, par, oh_bit, pay_en;
  logic [UW-1:0] unit;
  logic [SW-1:0] sf;
  oh_fields_t    fields_in, fields_cur;
  oh_kind_e      kind;

  assign fields_in = '{x: x_i, feac: feac_i, febe: febe_i, dl: dl_i, udl: udl_i};
  assign pay_en    = bit_en_i && !oh_slot;

  ds3_pos_counter #(.PAY_BITS(PAY_BITS)) u_pos (
    .clk_i, .rst_ni, .en_i(bit_en_i), .oh_slot_o(oh_slot), .unit_o(unit),
    .sf_o(sf), .mf_first_o(mf_first), .mf_last_o(mf_last)
  );

  ds3_parity_acc u_par (
    .clk_i, .rst_ni, .pay_en_i(pay_en), .data_i(pay_data_i),
    .mf_last_i(mf_last), .par_o(par)
  );

  ds3_oh_snapshot u_snap (
    .clk_i, .rst_ni, .load_i(bit_en_i && mf_first),
    .fields_i(fields_in), .fields_o(fields_cur)
  );

  ds3_oh_mux u_mux (
    .unit_i(unit), .sf_i(sf), .par_i(par), .fields_i(fields_cur),
    .kind_o(kind), .bit_o(oh_bit)
  );

  assign pay_req_o  = pay_en;
  assign mf_start_o = bit_en_i && mf_first;
  assign ser_o      = oh_slot ? oh_bit : pay_data_i;
endmodule

// File: rtl/ds3_oh_inserter_chk.sv
module ds3_oh_inserter_chk #(
  parameter int PAY_BITS = 84
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       pay_data_i,
  input logic       x_i,
  input logic       feac_i,
  input logic [2:0] febe_i,
  input logic [2:0] dl_i,
  input logic [7:0] udl_i,
  input logic       pay_req_o,
  input logic       ser_o,
  input logic       mf_start_o
);
  localparam int FRAME_BITS = (PAY_BITS + 1) * 56;
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] FRAME_N = CW'(FRAME_BITS);
  localparam logic [CW-1:0] PAY_N   = CW'(PAY_BITS * 56);

  logic [CW-1:0] en_cnt, pay_cnt;
  logic          seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_cnt  <= '0;
      pay_cnt <= '0;
      seen    <= 1'b0;
    end else if (bit_en_i) begin
      if (mf_start_o) begin
        en_cnt  <= CW'(1);
        pay_cnt <= '0;
        seen    <= 1'b1;
      end else begin
        en_cnt  <= en_cnt + 1'b1;
        pay_cnt <= pay_cnt + CW'(pay_req_o);
      end
    end
  end

  // R1
  mf_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_start_o && seen) |-> en_cnt == FRAME_N);
  // R1
  start_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mf_start_o && pay_req_o));
  // R2
  pay_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_start_o && seen) |-> pay_cnt == PAY_N);
  // R2
  pay_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_req_o |-> ser_o == pay_data_i);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |-> !pay_req_o && !mf_start_o);
  // R10
  first_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !seen) |-> mf_start_o);
endmodule

bind ds3_oh_inserter ds3_oh_inserter_chk #(.PAY_BITS(PAY_BITS)) chk_i (.*);

// File: tb/ds3_oh_inserter_tb_top.sv
`timescale 1ns/1ps
module ds3_oh_inserter_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en = 1'b0, pay_data = 1'b0, x_in = 1'b0, feac_in = 1'b0;
  logic [2:0] febe_in = '0, dl_in = '0;
  logic [7:0] udl_in = '0;
  logic       pay_req, ser, mf_start;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit exp_par = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0;

  always #2 clk = ~clk;

  ds3_oh_inserter dut_i (
    .clk_i(clk), .rst_ni, .bit_en_i(bit_en), .pay_data_i(pay_data),
    .x_i(x_in), .feac_i(feac_in), .febe_i(febe_in), .dl_i(dl_in), .udl_i(udl_in),
    .pay_req_o(pay_req), .ser_o(ser), .mf_start_o(mf_start)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic set_fields(input logic x, input logic fe, input logic [2:0] fb,
                            input logic [2:0] d, input logic [7:0] u);
    x_in = x; feac_in = fe; febe_in = fb; dl_in = d; udl_in = u;
  endtask

  // pat: 0 zeros, 1 ones, 2 pseudo-random, 3 alternating
  task automatic run_mf(input int pat, input bit gaps, input bit mid_change);
    int pos = 0;
    bit acc = 1'b0;
    logic s_x, s_fe;
    logic [2:0] s_fb, s_dl;
    logic [7:0] s_udl;
    while (pos < 4760) begin
      bit en, pd, is_oh, e_ser;
      int sf, u, b, k;
      string tag;
      @(negedge clk);
      cyc++;
      en = !(gaps && (cyc % 7 == 3));
      case (pat)
        0: pd = 1'b0;
        1: pd = 1'b1;
        2: pd = next_rand();
        default: pd = pos[0];
      endcase
      bit_en = en;
      pay_data = pd;
      if (mid_change && pos == 1000)
        set_fields(~x_in, ~feac_in, ~febe_in, ~dl_in, ~udl_in);
      #1;
      if (!en) begin
        chk(pay_req == 1'b0, "R9", "pay_req idle", pay_req, 0);
        chk(mf_start == 1'b0, "R9", "mf_start idle", mf_start, 0);
        continue;
      end
      b = pos % 85; u = (pos / 85) % 8; sf = pos / 680;
      is_oh = (b == 0);
      if (pos == 0) begin
        s_x = x_in; s_fe = feac_in; s_fb = febe_in; s_dl = dl_in; s_udl = udl_in;
      end
      k = (u - 2) / 2;
      e_ser = pd; tag = "R2 payload";
      if (is_oh) begin
        if (u == 0) begin
          if (sf < 2)      begin e_ser = s_x;      tag = "R4 X"; end
          else if (sf < 4) begin e_ser = exp_par;  tag = "R7 P"; end
          else             begin e_ser = (sf == 5); tag = "R4 M"; end
        end else if (u == 1 || u == 7) begin e_ser = 1'b1; tag = "R3 F1"; end
        else if (u == 3 || u == 5)      begin e_ser = 1'b0; tag = "R3 F0"; end
        else begin
          case (sf)
            0: if (k < 2) begin e_ser = 1'b1; tag = "R6 AIC/NA"; end
               else       begin e_ser = s_fe; tag = "R5 FEAC"; end
            1: if (k == 1) begin e_ser = 1'b1; tag = "R6 NA"; end
               else        begin e_ser = s_udl[k/2]; tag = "R5 UDL sf1"; end
            2: begin e_ser = exp_par;    tag = "R7 CP"; end
            3: begin e_ser = s_fb[k];    tag = "R5 FEBE"; end
            4: begin e_ser = s_dl[k];    tag = "R5 DL"; end
            5: begin e_ser = s_udl[2+k]; tag = "R5 UDL sf5"; end
            default: begin e_ser = s_udl[5+k]; tag = "R5 UDL sf6"; end
          endcase
        end
        if (mid_change) tag = {tag, " R8"};
      end
      chk(ser == e_ser, tag, $sformatf("ser pos %0d", pos), ser, e_ser);
      chk(pay_req == !is_oh, "R2", $sformatf("pay_req pos %0d", pos), pay_req, !is_oh);
      chk(mf_start == (pos == 0), "R1", $sformatf("mf_start pos %0d", pos), mf_start, pos == 0);
      if (!is_oh) acc ^= pd;
      pos++;
    end
    exp_par = acc;
  endtask

  task automatic test_reset();
    rst_ni = 1'b0; bit_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(pay_req == 1'b0, "R10", "pay_req in reset", pay_req, 0);
    chk(mf_start == 1'b0, "R10", "mf_start in reset", mf_start, 0);
    rst_ni = 1'b1;
    repeat (5) begin
      @(negedge clk); #1;
      chk(pay_req == 1'b0 && mf_start == 1'b0, "R9", "outputs with enable low", {pay_req, mf_start}, 0);
    end
    exp_par = 1'b0;
  endtask

  // R10 R7: first frame after reset carries zero parity
  task automatic test_first_frame();
    set_fields(1'b1, 1'b0, 3'b101, 3'b010, 8'b1010_0110);
    run_mf(2, 1'b0, 1'b0);
  endtask

  // R7: parity follows the payload of the preceding frame
  task automatic test_parity_patterns();
    set_fields(1'b0, 1'b1, 3'b011, 3'b110, 8'b0101_1001);
    run_mf(1, 1'b0, 1'b0);
    run_mf(3, 1'b0, 1'b0);
    run_mf(2, 1'b0, 1'b0);
  endtask

  // R9: stalls hold the position
  task automatic test_gaps();
    set_fields(1'b1, 1'b1, 3'b100, 3'b001, 8'b1100_0011);
    run_mf(2, 1'b1, 1'b0);
  endtask

  // R8: mid-frame field change lands in the next frame
  task automatic test_mid_change();
    set_fields(1'b0, 1'b0, 3'b010, 3'b101, 8'b0011_1100);
    run_mf(0, 1'b0, 1'b1);
    run_mf(2, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_first_frame();
    test_parity_patterns();
    test_gaps();
    test_mid_change();
    @(negedge clk); bit_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule